// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style serial port reports to its host. It watches five source conditions: a receiver line-status error, received data waiting, a character timeout, the transmit holding register going empty, and a modem-status change. A 4-bit enable value masks them, and the block ranks the survivors by a fixed priority. The winner is presented as a 4-bit identification value: bit 0 is a pending flag that is low when an interrupt is pending, and bits 3:1 carry the source code. A registered interrupt line follows the inverse of the pending flag.

The transmitter-empty condition is held by the block itself, because it is an event and not a level. It is armed when the holding register becomes empty, or when its enable is turned on while the register is already empty. It is disarmed by a write into the transmit FIFO, or by a read of the identification value while that value shows the transmitter-empty code. The other four sources are levels owned by the surrounding receiver and modem logic.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `iir_o` is 4'b0001 and `irq_o` is 0.
- R2: Enable bit 0 gates both data-available and character-timeout, bit 1 gates transmitter-empty, bit 2 gates line status and bit 3 gates modem status. A source whose enable is 0 never appears in `iir_o`.
- R3: A reported source gives `iir_o[0]`=0 and `iir_o[3:1]` set to its code: line status 3'b011, data available 3'b010, character timeout 3'b110, transmitter empty 3'b001, modem status 3'b000.
- R4: When several enabled sources are active, the one reported is the first in this order: line status, data available, character timeout, transmitter empty, modem status.
- R5: When no enabled source is active, `iir_o` is 4'b0001.
- R6: `iir_o` reflects the inputs and enable bits present at the previous rising clock edge (one register of latency).
- R7: `irq_o` is registered and equals the inverse of `iir_o[0]` in every cycle.
- R8: The transmitter-empty source is armed at an edge where `thr_empty_i` is 1 and either was 0 at the previous edge or `ien_i[1]` rises from 0 to 1.
- R9: A `tx_wr_i` pulse disarms the transmitter-empty source at that edge. If arming and disarming coincide, disarming wins.
- R10: An `iir_rd_i` pulse disarms the transmitter-empty source only if `iir_o` shows 4'b0010 in that cycle. A read while another code is shown leaves it armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien_i | input | 4 | Interrupt enable value |
| lsr_i | input | 1 | Receiver line-status error active |
| rda_i | input | 1 | Received data available |
| cto_i | input | 1 | Character timeout active |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| msr_i | input | 1 | Modem-status change active |
| tx_wr_i | input | 1 | Write into the transmit FIFO (one-cycle pulse) |
| iir_rd_i | input | 1 | Read of the identification value (one-cycle pulse) |
| iir_o | output | 4 | Identification value: bit 0 not-pending, bits 3:1 source code |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The only hidden state is the armed transmitter-empty flag and the sampled previous empty and enable levels. A wrong flag shows at the ports as a spurious or missing 4'b0010, one cycle after the edge that should have armed or cleared it, provided no higher source masks it. The bench therefore clears the higher sources around every arm, clear and read case, and compares both outputs with a behavioural model every cycle. Priority or code errors appear in the cycle after the offending input combination is applied.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IEN_W   = 4;
  localparam int CODE_W  = 3;
  localparam int IIR_W   = CODE_W + 1;
  localparam int NSRC    = 5;

  // enable bit positions
  localparam int EN_DATA = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  // source ranks, 0 = highest priority
  localparam int RK_LINE = 0;
  localparam int RK_DATA = 1;
  localparam int RK_TOUT = 2;
  localparam int RK_THRE = 3;
  localparam int RK_MDM  = 4;

  localparam logic [CODE_W-1:0] CODE_LINE = 3'b011;
  localparam logic [CODE_W-1:0] CODE_DATA = 3'b010;
  localparam logic [CODE_W-1:0] CODE_TOUT = 3'b110;
  localparam logic [CODE_W-1:0] CODE_THRE = 3'b001;
  localparam logic [CODE_W-1:0] CODE_MDM  = 3'b000;

  function automatic logic [CODE_W-1:0] code_of(input int rank);
    case (rank)
      RK_LINE: code_of = CODE_LINE;
      RK_DATA: code_of = CODE_DATA;
      RK_TOUT: code_of = CODE_TOUT;
      RK_THRE: code_of = CODE_THRE;
      default: code_of = CODE_MDM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thre.sv
// Holds the transmitter-empty event; exposes its next value so the
// identification register sees arm/clear in the same edge.
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_i,
  input  logic wr_clr_i,
  input  logic rd_clr_i,
  output logic flag_d_o
);
  logic flag_q, empty_q, en_q;
  logic arm;

  always_comb begin
    arm      = empty_i & (~empty_q | (en_i & ~en_q));
    flag_d_o = (flag_q | arm) & ~wr_clr_i & ~rd_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      empty_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      flag_q  <= flag_d_o;
      empty_q <= empty_i;
      en_q    <= en_i;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority selection, index 0 highest.
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      req_i,
  output logic              pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0] grant;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_grant
      if (gi == 0) begin : g_top
        assign grant[gi] = req_i[gi];
      end else begin : g_rest
        assign grant[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code_o = code_o | code_of(i);
    end
    pend_o = |req_i;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien_i,
  input  logic             lsr_i,
  input  logic             rda_i,
  input  logic             cto_i,
  input  logic             thr_empty_i,
  input  logic             msr_i,
  input  logic             tx_wr_i,
  input  logic             iir_rd_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);
  logic              thre_d;
  logic              rd_clr;
  logic [NSRC-1:0]   req;
  logic              pend;
  logic [CODE_W-1:0] code;
  logic [IIR_W-1:0]  iir_q, iir_d;
  logic              irq_q, irq_d;

  assign rd_clr = iir_rd_i & (iir_q == {CODE_THRE, 1'b0});

  uart_irq_thre u_thre (
    .clk      (clk),
    .rst_n    (rst_n),
    .empty_i  (thr_empty_i),
    .en_i     (ien_i[EN_THRE]),
    .wr_clr_i (tx_wr_i),
    .rd_clr_i (rd_clr),
    .flag_d_o (thre_d)
  );

  always_comb begin
    req          = '0;
    req[RK_LINE] = lsr_i  & ien_i[EN_LINE];
    req[RK_DATA] = rda_i  & ien_i[EN_DATA];
    req[RK_TOUT] = cto_i  & ien_i[EN_DATA];
    req[RK_THRE] = thre_d & ien_i[EN_THRE];
    req[RK_MDM]  = msr_i  & ien_i[EN_MDM];
  end

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i  (req),
    .pend_o (pend),
    .code_o (code)
  );

  always_comb begin
    iir_d = {code, ~pend};
    irq_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {{CODE_W{1'b0}}, 1'b1};
      irq_q <= 1'b0;
    end else begin
      iir_q <= iir_d;
      irq_q <= irq_d;
    end
  end

  assign iir_o = iir_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ien_i,
  input logic       lsr_i,
  input logic       rda_i,
  input logic       tx_wr_i,
  input logic [3:0] iir_o,
  input logic       irq_o
);
  p_irq_follows_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !iir_o[0]);

  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[0] |-> (iir_o[3:1] == 3'b000));

  p_all_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i == 4'b0000) |=> (iir_o == 4'b0001));

  p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_i && ien_i[2]) |=> (iir_o == 4'b0110));

  p_data_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_i && ien_i[0] && !(lsr_i && ien_i[2])) |=> (iir_o == 4'b0100));

  p_wr_clears_thre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_i && ien_i == 4'b0010) |=> (iir_o == 4'b0001));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ien_i   (ien_i),
  .lsr_i   (lsr_i),
  .rda_i   (rda_i),
  .tx_wr_i (tx_wr_i),
  .iir_o   (iir_o),
  .irq_o   (irq_o)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ien = 4'b0000;
  logic       lsr = 1'b0, rda = 1'b0, cto = 1'b0, emp = 1'b0, msr = 1'b0;
  logic       txw = 1'b0, rd = 1'b0;
  logic [3:0] iir;
  logic       irq;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ien_i(ien), .lsr_i(lsr), .rda_i(rda),
    .cto_i(cto), .thr_empty_i(emp), .msr_i(msr), .tx_wr_i(txw),
    .iir_rd_i(rd), .iir_o(iir), .irq_o(irq));

  // behavioural reference
  logic [3:0] m_iir = 4'b0001;
  logic       m_irq = 1'b0;
  bit m_thre = 0, m_pemp = 0, m_pen = 0;

  always @(posedge clk) begin
    bit arm, clr, nt;
    logic [3:0] v;
    if (!rst_n) begin
      m_thre = 0; m_pemp = 0; m_pen = 0;
      m_iir = 4'b0001; m_irq = 1'b0;
    end else begin
      arm = emp && (!m_pemp || (ien[1] && !m_pen));
      clr = txw || (rd && m_iir == 4'b0010);
      nt  = clr ? 1'b0 : (m_thre || arm);
      if      (lsr && ien[2]) v = 4'b0110;
      else if (rda && ien[0]) v = 4'b0100;
      else if (cto && ien[0]) v = 4'b1100;
      else if (nt  && ien[1]) v = 4'b0010;
      else if (msr && ien[3]) v = 4'b0000;
      else                    v = 4'b0001;
      m_thre = nt; m_pemp = emp; m_pen = ien[1];
      m_iir = v; m_irq = !v[0];
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (iir !== m_iir || irq !== m_irq) begin
        fails++;
        $display("FAIL %s iir=%b irq=%b expected iir=%b irq=%b", tag, iir, irq, m_iir, m_irq);
      end
    end
  endtask

  task automatic expect_iir(string t, logic [3:0] e);
    checks++;
    if (iir !== e) begin
      fails++;
      $display("FAIL %s iir=%b expected %b", t, iir, e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1 reset state
    tag = "R1"; cyc(2);
    checks++;
    if (iir !== 4'b0001 || irq !== 1'b0) begin
      fails++; $display("FAIL R1 iir=%b irq=%b expected 0001 0", iir, irq);
    end
    rst_n = 1'b1; cyc(1);
    expect_iir("R1", 4'b0001);

    // R3 each code alone, R6 one-cycle latency
    tag = "R3"; ien = 4'b1111;
    lsr = 1; cyc(1); expect_iir("R3 line", 4'b0110); lsr = 0;
    rda = 1; cyc(1); expect_iir("R3 data", 4'b0100); rda = 0;
    cto = 1; cyc(1); expect_iir("R3 timeout", 4'b1100); cto = 0;
    msr = 1; cyc(1); expect_iir("R3 modem", 4'b0000); msr = 0;
    tag = "R5"; cyc(1); expect_iir("R5 idle", 4'b0001);

    // R2 masking
    tag = "R2";
    ien = 4'b1011; lsr = 1; cyc(1); expect_iir("R2 line masked", 4'b0001); lsr = 0;
    ien = 4'b1110; rda = 1; cto = 1; cyc(1); expect_iir("R2 data masked", 4'b0001);
    rda = 0; cto = 0;
    ien = 4'b0111; msr = 1; cyc(1); expect_iir("R2 modem masked", 4'b0001);
    // R6 enable change seen next cycle
    tag = "R6"; ien = 4'b1111; cyc(1); expect_iir("R6 enable", 4'b0000); msr = 0;

    // R4 priority
    tag = "R4";
    lsr = 1; rda = 1; cto = 1; msr = 1; cyc(1); expect_iir("R4 line top", 4'b0110);
    lsr = 0; cyc(1); expect_iir("R4 data over timeout", 4'b0100);
    rda = 0; cyc(1); expect_iir("R4 timeout over modem", 4'b1100);
    cto = 0; cyc(1); expect_iir("R4 modem last", 4'b0000);
    msr = 0; cyc(2);

    // R8 arm on empty rise
    tag = "R8"; emp = 1; cyc(1); expect_iir("R8 arm", 4'b0010);
    cyc(2);
    msr = 1; cyc(1); expect_iir("R4 thre over modem", 4'b0010);
    // R9 write clears
    tag = "R9"; txw = 1; cyc(1); txw = 0; expect_iir("R9 write clear", 4'b0000);
    msr = 0; cyc(1);
    // R8 arm on enable rise while empty
    tag = "R8"; ien = 4'b1101; cyc(2); expect_iir("R8 masked", 4'b0001);
    ien = 4'b1111; cyc(1); expect_iir("R8 enable arm", 4'b0010);
    // R10 read while hidden keeps it
    tag = "R10"; lsr = 1; cyc(1); rd = 1; cyc(1); rd = 0;
    lsr = 0; cyc(1); expect_iir("R10 hidden read keeps", 4'b0010);
    rd = 1; cyc(1); rd = 0; expect_iir("R10 read clears", 4'b0001);
    cyc(2);
    // R9 arm and clear together
    tag = "R9"; emp = 0; cyc(1);
    emp = 1; txw = 1; cyc(1); txw = 0; expect_iir("R9 clear wins", 4'b0001);
    cyc(2);
    // falling and staying empty no rearm
    tag = "R8"; emp = 1; cyc(3); expect_iir("R8 level no rearm", 4'b0001);
    // mixed patterns
    tag = "R7";
    for (int k = 0; k < 200; k++) begin
      ien = 4'(k * 7 + 3); lsr = k[2]; rda = k[3] ^ k[0]; cto = k[1];
      msr = k[4]; emp = k[5] | k[1]; txw = (k % 9 == 0); rd = (k % 5 == 0);
      cyc(1);
    end
    txw = 0; rd = 0; cyc(1);
    // asynchronous reset mid-run
    tag = "R1"; lsr = 1; ien = 4'b0100; cyc(1);
    #1 rst_n = 0; #0.5;
    expect_iir("R1 async", 4'b0001);
    cyc(1); rst_n = 1; lsr = 0; cyc(2);
    done = 1;
    summary();
  end
endmodule